// File: doc/BRIEF.md
# Automatic CTS/RTS Flow Controller

This block applies hardware flow control to one serial channel. On the transmit side it takes the active-low clear-to-send input from the remote end and passes it through a synchronizer. When automatic transmit gating is enabled, the block withholds permission to begin a new character while the remote end reports that it is not ready. A character that has already begun is never cut short. Permission is evaluated only at character boundaries, which the transmitter marks with start and end strobes.

On the receive side the block compares the receive FIFO fill level with a programmed trigger level and drives the active-low request-to-send output. In automatic mode the block deasserts the output, driving it high, when the level reaches the trigger. It asserts the output again once the level falls back below the trigger. An automatic deassertion also sets a sticky interrupt flag, which stays set until a clear strobe arrives.

Automatic request-to-send control acts only while the software value of the output is low. When automatic mode is off, or when software holds its value high, the output simply follows the software value.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset `rts_n` is 1 and `flow_irq` is 0. With automatic transmit gating off, `tx_permit` is 1.
- R2: While `auto_cts_en` is 0, `tx_permit` is 1 whatever the value of `cts_n`.
- R3: While `auto_cts_en` is 1 and no character is in progress, `tx_permit` equals the inverse of `cts_n` as sampled at the second rising clock edge before the current one (two-stage synchronizer). The synchronizer resets to the not-ready value 1.
- R4: From the clock edge that samples `tx_char_start` high until the edge that samples `tx_char_end` high, `tx_permit` stays 1 whatever `cts_n` does.
- R5: With `auto_rts_en` 1 and `sw_rts_n` 0, `rts_n` becomes 1 at the clock edge after `rx_level` >= `rx_trigger` (unsigned comparison). This includes the case where the trigger is at its maximum value.
- R6: With `auto_rts_en` 1 and `sw_rts_n` 0, `rts_n` becomes 0 at the clock edge after `rx_level` < `rx_trigger`.
- R7: When `auto_rts_en` is 0 or `sw_rts_n` is 1, `rts_n` takes the value of `sw_rts_n` at the next clock edge, and the FIFO level has no effect.
- R8: A 0-to-1 transition of `rts_n` caused by automatic control sets `flow_irq` at the same edge. The flag stays 1 until an edge that samples `irq_clr` high. A new automatic deassertion in the same cycle as `irq_clr` wins, and the flag stays 1.
- R9: A rise of `rts_n` that comes from the software value does not set `flow_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_cts_en | input | 1 | Enables automatic transmit gating |
| auto_rts_en | input | 1 | Enables automatic request-to-send control |
| cts_n | input | 1 | Active-low clear-to-send from the remote end (asynchronous) |
| tx_char_start | input | 1 | Strobe: transmitter begins a character |
| tx_char_end | input | 1 | Strobe: transmitter finishes a character |
| rx_level | input | LEVEL_W | Current receive FIFO fill level |
| rx_trigger | input | LEVEL_W | Programmed trigger level |
| sw_rts_n | input | 1 | Software value of request-to-send |
| irq_clr | input | 1 | Read-clear strobe for the interrupt flag |
| tx_permit | output | 1 | High when a new character may begin |
| rts_n | output | 1 | Active-low request-to-send output |
| flow_irq | output | 1 | Sticky flow-control interrupt flag |

## Verification
The bench builds the block with LEVEL_W = 4 and the default two synchronizer stages. The narrow level field lets the stimulus drive the trigger to its maximum value of 15 and sweep levels on both sides of it. This exercises the boundary comparison without long fill sequences. Keeping the two-stage synchronizer lets the bench check, cycle by cycle, that a clear-to-send change has no effect after one edge and takes effect after the second.

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int LEVEL_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_cts_en,
  input  logic               auto_rts_en,
  input  logic               cts_n,
  input  logic               tx_char_start,
  input  logic               tx_char_end,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [LEVEL_W-1:0] rx_trigger,
  input  logic               sw_rts_n,
  input  logic               irq_clr,
  output logic               tx_permit,
  output logic               rts_n,
  output logic               flow_irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cts_sync;
  logic                   cts_safe;
  logic                   in_char;
  logic                   auto_active;
  logic                   fifo_full_ish;
  logic                   rts_q;
  logic                   irq_q;
  logic                   auto_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cts_sync <= '1;
    else        cts_sync <= {cts_sync[LAST-1:0], cts_n};

  assign cts_safe = cts_sync[LAST];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              in_char <= 1'b0;
    else if (tx_char_start)  in_char <= 1'b1;
    else if (tx_char_end)    in_char <= 1'b0;

  assign tx_permit = in_char | ~auto_cts_en | ~cts_safe;

  assign auto_active   = auto_rts_en & ~sw_rts_n;
  assign fifo_full_ish = (rx_level >= rx_trigger);
  assign auto_rise     = auto_active & fifo_full_ish & ~rts_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           rts_q <= 1'b1;
    else if (auto_active) rts_q <= fifo_full_ish;
    else                  rts_q <= sw_rts_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         irq_q <= 1'b0;
    else if (auto_rise) irq_q <= 1'b1;
    else if (irq_clr)   irq_q <= 1'b0;

  assign rts_n    = rts_q;
  assign flow_irq = irq_q;

  // R4: a started character keeps permission
  a_r4_char_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_char_start && !tx_char_end) |=> tx_permit);

  // R2
  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_permit);

  // R5
  a_r5_auto_deassert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && !sw_rts_n && rx_level >= rx_trigger) |=> rts_n);

  // R6
  a_r6_auto_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && !sw_rts_n && rx_level < rx_trigger) |=> !rts_n);

  // R7
  a_r7_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rts_en || sw_rts_n) |=> (rts_n == $past(sw_rts_n)));

  // R8
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && !sw_rts_n && rx_level >= rx_trigger && !rts_n) |=> flow_irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_irq && !irq_clr) |=> flow_irq);

  // R9
  a_r9_no_sw_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_irq && (!auto_rts_en || sw_rts_n)) |=> !flow_irq);

endmodule

// File: tb/uart_flow_ctrl_bench.sv
module uart_flow_ctrl_bench;
  localparam int LW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic auto_cts_en = 0, auto_rts_en = 0, cts_n = 1;
  logic tx_char_start = 0, tx_char_end = 0;
  logic [LW-1:0] rx_level = '0, rx_trigger = 4'd8;
  logic sw_rts_n = 1, irq_clr = 0;
  logic tx_permit, rts_n, flow_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_flow_ctrl #(.LEVEL_W(LW), .SYNC_STAGES(2)) u_uart_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .cts_n(cts_n), .tx_char_start(tx_char_start), .tx_char_end(tx_char_end),
    .rx_level(rx_level), .rx_trigger(rx_trigger), .sw_rts_n(sw_rts_n),
    .irq_clr(irq_clr), .tx_permit(tx_permit), .rts_n(rts_n), .flow_irq(flow_irq));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
    check("R1 rts_n", rts_n, 1'b1);
    check("R1 flow_irq", flow_irq, 1'b0);
    check("R1 tx_permit", tx_permit, 1'b1);
  endtask

  task automatic t_gate_off;
    auto_cts_en = 0;
    cts_n = 1;
    tick(3);
    check("R2 cts high ignored", tx_permit, 1'b1);
    cts_n = 0;
    tick(1);
    check("R2 cts low", tx_permit, 1'b1);
    cts_n = 1;
    tick(3);
  endtask

  task automatic t_gate_on;
    auto_cts_en = 1;
    tick(1);
    check("R3 blocked while not ready", tx_permit, 1'b0);
    cts_n = 0;
    tick(1);
    check("R3 one edge not enough", tx_permit, 1'b0);
    tick(1);
    check("R3 ready after two edges", tx_permit, 1'b1);
    cts_n = 1;
    tick(1);
    check("R3 stop delayed one", tx_permit, 1'b1);
    tick(1);
    check("R3 stop after two", tx_permit, 1'b0);
  endtask

  task automatic t_char;
    cts_n = 0;
    tick(2);
    check("R3 ready before char", tx_permit, 1'b1);
    tx_char_start = 1;
    tick(1);
    tx_char_start = 0;
    cts_n = 1;
    tick(3);
    check("R4 char in progress", tx_permit, 1'b1);
    tx_char_end = 1;
    tick(1);
    tx_char_end = 0;
    check("R4 next char held", tx_permit, 1'b0);
    cts_n = 0;
    tick(2);
    auto_cts_en = 0;
  endtask

  task automatic t_auto_rts;
    auto_rts_en = 1;
    sw_rts_n = 0;
    rx_trigger = 4'd8;
    rx_level = 4'd0;
    tick(1);
    check("R6 below trigger", rts_n, 1'b0);
    rx_level = 4'd7;
    tick(1);
    check("R6 one below", rts_n, 1'b0);
    check("R8 no irq yet", flow_irq, 1'b0);
    rx_level = 4'd8;
    tick(1);
    check("R5 at trigger", rts_n, 1'b1);
    check("R8 irq set", flow_irq, 1'b1);
    rx_level = 4'd12;
    tick(1);
    check("R5 above trigger", rts_n, 1'b1);
    rx_level = 4'd7;
    tick(1);
    check("R6 back below", rts_n, 1'b0);
    check("R8 irq sticky", flow_irq, 1'b1);
    irq_clr = 1;
    tick(1);
    irq_clr = 0;
    check("R8 cleared", flow_irq, 1'b0);
    rx_level = 4'd15;
    irq_clr = 1;
    tick(1);
    irq_clr = 0;
    check("R8 set beats clear", flow_irq, 1'b1);
    rx_level = 4'd0;
    irq_clr = 1;
    tick(1);
    irq_clr = 0;
    rx_trigger = 4'd15;
    rx_level = 4'd14;
    tick(1);
    check("R6 max trigger below", rts_n, 1'b0);
    rx_level = 4'd15;
    tick(1);
    check("R5 max trigger reached", rts_n, 1'b1);
    rx_level = 4'd0;
    irq_clr = 1;
    tick(1);
    irq_clr = 0;
    rx_trigger = 4'd8;
  endtask

  task automatic t_sw_rts;
    auto_rts_en = 1;
    sw_rts_n = 0;
    rx_level = 4'd0;
    tick(1);
    check("R6 low before sw test", rts_n, 1'b0);
    sw_rts_n = 1;
    rx_level = 4'd15;
    tick(1);
    check("R7 sw high wins", rts_n, 1'b1);
    check("R9 no irq on sw rise", flow_irq, 1'b0);
    auto_rts_en = 0;
    sw_rts_n = 0;
    tick(1);
    check("R7 auto off level ignored", rts_n, 1'b0);
    sw_rts_n = 1;
    tick(1);
    check("R7 follows sw", rts_n, 1'b1);
    check("R9 still no irq", flow_irq, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_gate_off();
    t_gate_on();
    t_char();
    t_auto_rts();
    t_sw_rts();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule